// File: doc/BRIEF.md
# Byte Table Lookup Permuter

This block is a byte-gather unit for a SIMD datapath. A 32-bit selector word carries four independent 8-bit lane indices. Each index addresses one byte of a small lookup table, given as a flat vector of up to four 64-bit entries. The byte it picks lands in the same lane of the 32-bit result. The table length in bytes is a runtime input, not a build-time constant.

When a lane's index reaches or passes the table length, the lane takes the same-position byte of a fallback word from the caller, so the result is never forced to zero. A parameter adds a registered output stage. When that stage is present, a valid strobe travels with each result and the result register loads only on strobed cycles.

Top module: `tblp_permuter`

## Requirements
- R1: Lane k of the selector (bits [8k+7:8k]) decides result bits [8k+7:8k], and each lane is resolved independently of the other lanes.
- R2: A lane is a hit only when its full 8-bit index, compared unsigned, is strictly less than the effective table length.
- R3: On a hit, index bits [4:3] select the 64-bit entry and bits [2:0] select the byte within it, with byte 0 least significant. Entry e occupies table bits [64e+63:64e], so table byte n is table bits [8n+7:8n].
- R4: On a miss, the lane's result byte is the byte of the fallback word at the same bit position.
- R5: A table length of 0 makes every lane a miss, so the result equals the fallback word.
- R6: Length values above 32 are treated as 32. Indices 32 to 255 then miss, and indices 0 to 31 hit.
- R7: With the registered stage (the default), inputs sampled at a rising edge while the strobe is high appear on the result one cycle later, with out_valid high. The result does not change before that edge.
- R8: While the input strobe is low, out_valid drops after the next edge and the result holds its last value, whatever the other inputs do.
- R9: During reset, out_valid is 0 and the result is all zeros.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe qualifying the inputs on this cycle |
| sel_word | input | 32 | Four 8-bit lane indices |
| fallback_word | input | 32 | Bytes used by lanes whose index misses |
| table_flat | input | 256 | Lookup table, byte n at bits [8n+7:8n] |
| table_len | input | 6 | Number of valid table bytes, 0 to 32 (larger values clamp) |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Gathered bytes |

## Verification
The clocked assertions check on every strobed cycle that:
- a lane flagged as a miss returns the fallback byte one cycle later;
- a lane flagged as a hit returns the table byte its index names;
- a zero length yields no hit;
- the strobe is forwarded with one cycle of latency;
- the result holds while the strobe is low.

Only the bench's sweeps can show that the hit decision itself is correct against the length: every index value from 0 to 255 in every lane, against lengths at the boundaries 0, 1, 8, 31, 32 and the clamped values above 32. The same applies to the exact-cycle timing of the result relative to the clock edge.

// File: rtl/tblp_pkg.sv
package tblp_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ENTRY_W = 64;
  localparam int unsigned BYTES_PER_ENTRY = ENTRY_W / BYTE_W;

  // Clamp a raw length request to the table capacity.
  function automatic int unsigned clamp_len(input int unsigned raw_len,
                                            input int unsigned cap);
    return (raw_len > cap) ? cap : raw_len;
  endfunction

  // Hit test: unsigned index strictly below the effective length.
  function automatic logic idx_in_range(input int unsigned idx,
                                        input int unsigned eff_len);
    return idx < eff_len;
  endfunction

endpackage

// File: rtl/tblp_lane.sv
module tblp_lane #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned LEN_W   = 6
) (
  input  logic [7:0]                  lane_idx,
  input  logic [LEN_W-1:0]            eff_len,
  input  logic [ENTRIES*64-1:0]       table_flat,
  input  logic [7:0]                  fallback_byte,
  output logic                        lane_hit,
  output logic [7:0]                  lane_byte
);
  localparam int unsigned MAX_BYTES = ENTRIES * tblp_pkg::BYTES_PER_ENTRY;
  localparam int unsigned ADDR_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  logic [ADDR_W-1:0] byte_addr;
  logic [7:0]        table_byte;

  assign byte_addr  = lane_idx[ADDR_W-1:0];
  assign table_byte = table_flat[byte_addr*8 +: 8];
  assign lane_hit   = tblp_pkg::idx_in_range(32'(lane_idx), 32'(eff_len));
  assign lane_byte  = lane_hit ? table_byte : fallback_byte;

endmodule

// File: rtl/tblp_stage.sv
module tblp_stage #(
  parameter int unsigned W       = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         d_valid,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q_valid <= 1'b0;
          q       <= '0;
        end else begin
          q_valid <= d_valid;
          if (d_valid) q <= d;
        end
      end
    end else begin : g_comb
      assign q_valid = d_valid;
      assign q       = d;
    end
  endgenerate

endmodule

// File: rtl/tblp_permuter.sv
module tblp_permuter #(
  parameter int unsigned LANES   = 4,
  parameter int unsigned ENTRIES = 4,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic [LANES*8-1:0]                    sel_word,
  input  logic [LANES*8-1:0]                    fallback_word,
  input  logic [ENTRIES*64-1:0]                 table_flat,
  input  logic [$clog2(ENTRIES*8+1)-1:0]        table_len,
  output logic                                  out_valid,
  output logic [LANES*8-1:0]                    result
);
  localparam int unsigned WORD_W    = LANES * tblp_pkg::BYTE_W;
  localparam int unsigned MAX_BYTES = ENTRIES * tblp_pkg::BYTES_PER_ENTRY;
  localparam int unsigned LEN_W     = $clog2(MAX_BYTES + 1);

  logic [LEN_W-1:0]  eff_len;
  logic [LANES-1:0]  lane_hit;
  logic [WORD_W-1:0] gathered;

  assign eff_len = LEN_W'(tblp_pkg::clamp_len(32'(table_len), MAX_BYTES));

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      tblp_lane #(.ENTRIES(ENTRIES), .LEN_W(LEN_W)) lane_i (
        .lane_idx     (sel_word[k*8 +: 8]),
        .eff_len      (eff_len),
        .table_flat   (table_flat),
        .fallback_byte(fallback_word[k*8 +: 8]),
        .lane_hit     (lane_hit[k]),
        .lane_byte    (gathered[k*8 +: 8])
      );
    end
  endgenerate

  tblp_stage #(.W(WORD_W), .REG_OUT(REG_OUT)) stage_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_valid(in_valid),
    .d      (gathered),
    .q_valid(out_valid),
    .q      (result)
  );

  generate
    if (REG_OUT) begin : g_chk
      p_strobe_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_strobe_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));
      p_empty_table_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && table_len == '0) |-> (lane_hit == '0));
      for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        p_miss_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
          (in_valid && !lane_hit[k]) |=>
            result[k*8 +: 8] == $past(fallback_word[k*8 +: 8]));
        p_hit_table_r3: assert property (@(posedge clk) disable iff (!rst_n)
          (in_valid && lane_hit[k]) |=>
            result[k*8 +: 8] ==
              8'($past(table_flat) >> (8 * $past(32'(sel_word[k*8 +: 5])))));
      end
    end
  endgenerate

endmodule

// File: tb/tblp_permuter_tb_top.sv
module tblp_permuter_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  sel_word;
  logic [31:0]  fallback_word;
  logic [255:0] table_flat;
  logic [5:0]   table_len;
  logic         out_valid;
  logic [31:0]  result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tblp_permuter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_word(sel_word),
    .fallback_word(fallback_word), .table_flat(table_flat),
    .table_len(table_len), .out_valid(out_valid), .result(result)
  );

  function automatic logic [7:0] model_byte(input logic [255:0] t,
      input int ix, input logic [7:0] fb, input int len);
    int eff;
    logic [63:0] ent;
    eff = (len > 32) ? 32 : len;
    if (ix < eff) begin
      ent = 64'(t >> (64 * (ix / 8)));
      return 8'(ent >> (8 * (ix % 8)));
    end
    return fb;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [31:0] act,
                            input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, capture at the rising edge, check just after it.
  task automatic run_vec(input logic [31:0] sw, input logic [31:0] fb,
                         input int len);
    logic [7:0] exp_b;
    int ix;
    string req;
    sel_word = sw; fallback_word = fb; table_len = 6'(len); in_valid = 1'b1;
    @(posedge clk); #1;
    check_bit("R7 out_valid", out_valid, 1'b1);
    for (int k = 0; k < 4; k++) begin
      ix = int'(sw[k*8 +: 8]);
      exp_b = model_byte(table_flat, ix, fb[k*8 +: 8], len);
      if (len == 0)                   req = "R5";
      else if (len > 32)              req = "R6";
      else if (ix < len)              req = "R3";
      else                            req = "R4";
      checks++;
      if (result[k*8 +: 8] !== exp_b) begin
        fails++;
        $display("FAIL %s R1 R2 lane=%0d idx=%0d len=%0d actual=%h expected=%h",
                 req, k, ix, len, result[k*8 +: 8], exp_b);
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lens [10] = '{0, 1, 7, 8, 9, 31, 32, 33, 40, 63};
    logic [31:0] held;
    rst_n = 1'b0; in_valid = 1'b1; sel_word = '0; fallback_word = 32'hFFFF_FFFF;
    table_len = 6'd32;
    for (int n = 0; n < 32; n++) table_flat[n*8 +: 8] = 8'(n * 29 + 17);
    repeat (3) @(posedge clk);
    #1;
    check_bit("R9 out_valid in reset", out_valid, 1'b0);
    check_word("R9 result in reset", result, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // Near-exhaustive sweep: every index value in every lane.
    for (int li = 0; li < 10; li++) begin
      for (int v = 0; v < 256; v++) begin
        run_vec({8'(v + 183), 8'(v + 122), 8'(v + 61), 8'(v)},
                $urandom(), lens[li]);
      end
      // Boundary lanes: 255, length, length-1, 0.
      run_vec({8'd255, 8'(lens[li]), 8'(lens[li] - 1), 8'd0},
              32'hA5C3_1E77, lens[li]);
    end

    // Second table with unstructured contents.
    for (int w = 0; w < 8; w++) table_flat[w*32 +: 32] = $urandom();
    for (int v = 0; v < 64; v++)
      run_vec($urandom(), $urandom(), v % 34);
    run_vec(32'h1F18_0700, 32'h0, 32);

    // R7: result must not move before the capturing edge.
    held = result;
    sel_word = 32'h0302_0100; fallback_word = 32'h0; table_len = 6'd32;
    in_valid = 1'b1;
    #1;
    check_word("R7 result before edge", result, held);
    @(posedge clk); #1;
    check_word("R7 result after edge",
               result, {table_flat[31:24], table_flat[23:16],
                        table_flat[15:8], table_flat[7:0]});
    @(negedge clk);

    // R8: strobe low, inputs change, result holds.
    held = result;
    in_valid = 1'b0; sel_word = 32'hFFFF_FFFF; fallback_word = 32'h1234_5678;
    table_len = 6'd0;
    @(posedge clk); #1;
    check_bit("R8 out_valid low", out_valid, 1'b0);
    check_word("R8 result held", result, held);
    @(posedge clk); #1;
    check_word("R8 result still held", result, held);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule